// File: doc/BRIEF.md
# Flash Write Qualifier and Sector-Group Protection

This block sits at the front of a byte-wide parallel NOR flash model. It runs on a fast system clock and samples the asynchronous chip-enable, write-enable and output-enable strobes, along with the address and data buses. It also samples three digital condition flags: supply-too-low, reset-pin-low and reset-pin-at-high-voltage. From these it decides whether a genuine bus write has taken place. For each accepted write it emits exactly one single-cycle strobe that carries the captured address and data.

The block holds one protection bit per group of four adjacent 64 KB sectors. The bits load through a synchronous port. A write that lands in a locked group is still forwarded, but it is tagged as blocked so that the command logic downstream can refuse to program or erase. While the reset pin shows the high-voltage condition, every lock is ignored. The stored bits are never altered by this mode, so they apply again once it ends.

The block also drives a command-reset line. This line tells the downstream state machine to return to array-read mode after power-up, while the supply is low, and while the reset pin is held low.

Top module: `flash_wr_qual`

## Requirements
- R1: A write cycle exists only while the synchronized strobes show chip-enable low, write-enable low and output-enable high together. If any one of these three conditions is missing, no cycle starts.
- R2: The write level must be seen on at least MIN_W consecutive clock samples (default 2) before the cycle counts. A shorter low pulse produces no strobe.
- R3: Each accepted cycle produces exactly one `wr_stb` pulse, one clock wide. The pulse follows the chip-enable or write-enable strobe returning high.
- R4: `wr_addr` holds the address sampled in the first cycle of the write level. Address changes later in the same cycle are ignored.
- R5: `wr_data` holds the data sampled in the last cycle before chip-enable or write-enable returns high.
- R6: If output-enable falls while chip-enable and write-enable are still low, the cycle is cancelled and no strobe follows.
- R7: While `supply_low` is high, `cmd_reset` is high and no strobe is issued. A cycle in progress when the flag rises is discarded.
- R8: After reset or any lockout, a write level that is already present produces no strobe when it ends. The strobes must first leave the write level and then enter it again.
- R9: `cmd_reset` is high while `rst_n` is low and for SYNC_N cycles after release. It is also high while `rp_low` is high.
- R10: The sector index is `addr[20:16]` and the group index is `addr[20:18]`, so protection bit i covers sectors 4i to 4i+3. With `wr_stb`, `wr_blocked` equals the bit of the target group.
- R11: The protection bits reset to all zero. A pulse on `prot_ld` loads `prot_din` into them, with bit i covering group i. At any other time they do not change.
- R12: While `rp_hv` is high, `wr_blocked` is 0 for every group. After `rp_hv` clears, the stored bits apply again unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| ce_n | input | 1 | Chip-enable strobe, active low, asynchronous |
| we_n | input | 1 | Write-enable strobe, active low, asynchronous |
| oe_n | input | 1 | Output-enable strobe, active low, asynchronous |
| supply_low | input | 1 | Supply below lockout level |
| rp_low | input | 1 | Reset pin driven low |
| rp_hv | input | 1 | Reset pin at high voltage (temporary unprotect) |
| addr | input | 21 | Byte address bus |
| din | input | 8 | Data bus in |
| prot_ld | input | 1 | Load strobe for the protection bits |
| prot_din | input | 8 | New protection bits, bit i for group i |
| wr_stb | output | 1 | One-cycle accepted-write event |
| wr_addr | output | 21 | Address captured for the event |
| wr_data | output | 8 | Data captured for the event |
| wr_blocked | output | 1 | Target group locked; downstream ignores program or erase |
| cmd_reset | output | 1 | Return downstream state machine to array read |

## Verification
The bench drives low pulses one sample wide and exactly MIN_W samples wide. A filter that is off by one would either pass the glitch or drop the shortest legal write. It changes the address and data in the middle of a cycle. A block that latched on the wrong edge would report the later address or the earlier data. It holds the write level across a supply lockout and then releases it. An unarmed qualifier would emit a phantom strobe when that level ends. It also checks the sector-group boundary pair 0x0BFFFF/0x0C0000, and turns the high-voltage unprotect mode on and off. A wrong group slice, or an override that clears the stored bits, would flip `wr_blocked` on one of those writes.

// File: rtl/fwg_pkg.sv
package fwg_pkg;
  localparam int ADDR_W   = 21;
  localparam int DATA_W   = 8;
  localparam int SECT_W   = 5;
  localparam int GRP_LOG2 = 2;
  localparam int GRP_W    = SECT_W - GRP_LOG2;
  localparam int NGRP     = 1 << GRP_W;

  typedef enum logic [1:0] {WS_IDLE, WS_PEND, WS_ACT} wstate_e;

  // Top address bits select one of the uniform sectors.
  function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_W];
  endfunction

  // Adjacent sectors are lumped into lock groups.
  function automatic logic [GRP_W-1:0] group_of(input logic [ADDR_W-1:0] a);
    logic [SECT_W-1:0] s;
    s = sector_of(a);
    return s[SECT_W-1 -: GRP_W];
  endfunction

  // Three-pin level that lets a bus write proceed.
  function automatic logic write_level(input logic ce_n, input logic we_n, input logic oe_n);
    return !ce_n && !we_n && oe_n;
  endfunction
endpackage

// File: rtl/fwg_sync.sv
module fwg_sync #(
  parameter int W = 1,
  parameter int N = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) stage_q[i] <= RST;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < N; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[N-1];
endmodule

// File: rtl/fwg_qual.sv
module fwg_qual
  import fwg_pkg::*;
#(
  parameter int SYNC_N = 2,
  parameter int MIN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_s,
  input  logic              we_n_s,
  input  logic              oe_n_s,
  input  logic              hold_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] data_s,
  output logic              stb,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic              cmd_reset
);
  localparam int WARM = SYNC_N;
  localparam int WW   = $clog2(WARM + 1);
  localparam int CW   = $clog2(MIN_W + 1);

  wstate_e       st_q;
  logic [WW-1:0] warm_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cond_run_q;
  logic          armed_q;

  // Named internal events
  logic wr_lvl, end_by_strobe, settled, go, start_evt, qual_evt, emit_evt, abort_evt;

  assign wr_lvl        = write_level(ce_n_s, we_n_s, oe_n_s);
  assign end_by_strobe = ce_n_s | we_n_s;
  assign settled       = (int'(warm_q) == WARM);
  assign go            = settled && !hold_s;
  assign start_evt     = go && (st_q == WS_IDLE) && wr_lvl && armed_q;
  assign qual_evt      = go && ((start_evt && (MIN_W <= 1)) ||
                         ((st_q == WS_PEND) && wr_lvl && (int'(cnt_q) >= MIN_W - 1)));
  assign emit_evt      = go && (st_q == WS_ACT) && !wr_lvl && end_by_strobe;
  assign abort_evt     = go && (st_q == WS_ACT) && !wr_lvl && !end_by_strobe;
  assign cmd_reset     = !go;

  // Settle counter: covers synchronizer fill after reset or lockout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    warm_q <= '0;
    else if (hold_s)               warm_q <= '0;
    else if (int'(warm_q) != WARM) warm_q <= warm_q + 1'b1;
  end

  // Arming: a fresh entry into the write level is required
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (!go)     armed_q <= 1'b0;
    else if (!wr_lvl) armed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= WS_IDLE;
      cnt_q    <= '0;
      stb      <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      stb <= 1'b0;
      if (!go) begin
        st_q <= WS_IDLE;
      end else begin
        case (st_q)
          WS_IDLE: if (start_evt) begin
            cap_addr <= addr_s;
            cap_data <= data_s;
            cnt_q    <= CW'(1);
            st_q     <= qual_evt ? WS_ACT : WS_PEND;
          end
          WS_PEND: begin
            if (!wr_lvl) st_q <= WS_IDLE;
            else begin
              cap_data <= data_s;
              if (qual_evt) st_q <= WS_ACT;
              else          cnt_q <= cnt_q + 1'b1;
            end
          end
          WS_ACT: begin
            if (wr_lvl) cap_data <= data_s;
            else begin
              st_q <= WS_IDLE;
              stb  <= emit_evt;
            end
          end
          default: st_q <= WS_IDLE;
        endcase
      end
    end
  end

  // Independent run-length of the write level, for checking only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cond_run_q <= '0;
    else if (!wr_lvl)                  cond_run_q <= '0;
    else if (int'(cond_run_q) < MIN_W) cond_run_q <= cond_run_q + 1'b1;
  end

  assert_one_clk_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
  assert_min_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_ACT && $past(st_q) != WS_ACT) |-> int'(cond_run_q) >= MIN_W);
  assert_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (st_q == WS_IDLE) && !stb);
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != WS_IDLE) |=> $stable(cap_addr));
  assert_fresh_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !$past(wr_lvl));
  assert_oe_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !stb);
endmodule

// File: rtl/fwg_prot.sv
module fwg_prot
  import fwg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [NGRP-1:0]   ld_val,
  input  logic              hv_s,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic              locked
);
  logic [NGRP-1:0] prot_q;
  logic [GRP_W-1:0] grp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  prot_q <= '0;
    else if (ld) prot_q <= ld_val;
  end

  assign grp    = group_of(tgt_addr);
  assign locked = prot_q[grp] & ~hv_s;

  assert_prot_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(prot_q));
endmodule

// File: rtl/flash_wr_qual.sv
module flash_wr_qual
  import fwg_pkg::*;
#(
  parameter int SYNC_N = 2,
  parameter int MIN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              supply_low,
  input  logic              rp_low,
  input  logic              rp_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              prot_ld,
  input  logic [NGRP-1:0]   prot_din,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_blocked,
  output logic              cmd_reset
);
  localparam int BUS_W = ADDR_W + DATA_W;

  logic [2:0]       strobe_s;
  logic [2:0]       flag_s;
  logic [BUS_W-1:0] bus_s;
  logic             stb, locked, hv_s, hold_s;

  // Strobes idle high; flags idle low; bus delayed to stay aligned
  fwg_sync #(.W(3), .N(SYNC_N), .RST(3'b111)) u_sync_strobe (
    .clk(clk), .rst_n(rst_n), .d({ce_n, we_n, oe_n}), .q(strobe_s));
  fwg_sync #(.W(3), .N(SYNC_N), .RST(3'b000)) u_sync_flag (
    .clk(clk), .rst_n(rst_n), .d({supply_low, rp_low, rp_hv}), .q(flag_s));
  fwg_sync #(.W(BUS_W), .N(SYNC_N), .RST('0)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(bus_s));

  assign hold_s = flag_s[2] | flag_s[1];
  assign hv_s   = flag_s[0];

  fwg_qual #(.SYNC_N(SYNC_N), .MIN_W(MIN_W)) u_qual (
    .clk(clk), .rst_n(rst_n),
    .ce_n_s(strobe_s[2]), .we_n_s(strobe_s[1]), .oe_n_s(strobe_s[0]),
    .hold_s(hold_s),
    .addr_s(bus_s[BUS_W-1 -: ADDR_W]), .data_s(bus_s[DATA_W-1:0]),
    .stb(stb), .cap_addr(wr_addr), .cap_data(wr_data), .cmd_reset(cmd_reset));

  fwg_prot u_prot (
    .clk(clk), .rst_n(rst_n), .ld(prot_ld), .ld_val(prot_din),
    .hv_s(hv_s), .tgt_addr(wr_addr), .locked(locked));

  assign wr_stb     = stb;
  assign wr_blocked = stb & locked;

  assert_hv_unlocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_blocked) |-> !hv_s);
  assert_no_stb_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_s |=> !wr_stb);
endmodule

// File: tb/flash_wr_qual_bench.sv
`timescale 1ns/1ps
module flash_wr_qual_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic supply_low = 1'b0, rp_low = 1'b0, rp_hv = 1'b0;
  logic [20:0] addr = '0;
  logic [7:0]  din = '0;
  logic        prot_ld = 1'b0;
  logic [7:0]  prot_din = '0;
  logic        wr_stb, wr_blocked, cmd_reset;
  logic [20:0] wr_addr;
  logic [7:0]  wr_data;

  int checks = 0, fails = 0, stb_cnt = 0;
  logic [20:0] last_addr = '0;
  logic [7:0]  last_data = '0;
  logic        last_blk = 1'b0;
  bit          done = 1'b0;

  localparam logic [7:0] PMASK = 8'hA5;
  // {address, data}; expected lock computed from PMASK in the loop
  localparam logic [28:0] VECS [7] = '{
    {21'h000123, 8'h3C}, {21'h040000, 8'h81}, {21'h0BFFFF, 8'hFF},
    {21'h0C0000, 8'h00}, {21'h17FFFF, 8'h5A}, {21'h1FFFFF, 8'hC3},
    {21'h1C0000, 8'h7E}};

  always #2 clk = ~clk;

  flash_wr_qual u_flash_wr_qual (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .supply_low(supply_low), .rp_low(rp_low), .rp_hv(rp_hv),
    .addr(addr), .din(din), .prot_ld(prot_ld), .prot_din(prot_din),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_blocked(wr_blocked), .cmd_reset(cmd_reset));

  always @(negedge clk) if (rst_n && wr_stb) begin
    stb_cnt++;
    last_addr = wr_addr;
    last_data = wr_data;
    last_blk  = wr_blocked;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic lock_of(input logic [7:0] mask, input logic [20:0] a);
    int g;
    g = int'(a) / 262144;  // four 64 KB sectors per group
    return mask[g];
  endfunction

  task automatic wr_cycle(input logic [20:0] a, input logic [7:0] d, input int lowlen);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    step(lowlen);
    ce_n = 1'b1; we_n = 1'b1;
    step(8);
  endtask

  task automatic load_prot(input logic [7:0] m);
    prot_din = m; prot_ld = 1'b1; step(1); prot_ld = 1'b0; step(1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    int base;
    step(3);
    chk(wr_stb == 1'b0, "R9 reset stb", 32'(wr_stb), 0);
    chk(cmd_reset == 1'b1, "R9 reset cmd_reset", 32'(cmd_reset), 1);
    rst_n = 1'b1;
    step(1);
    chk(cmd_reset == 1'b1, "R9 settle cmd_reset", 32'(cmd_reset), 1);
    step(6);
    chk(cmd_reset == 1'b0, "R9 released cmd_reset", 32'(cmd_reset), 0);

    // R11: reset protection is all clear
    base = stb_cnt;
    wr_cycle(21'h000010, 8'h11, 4);
    chk(stb_cnt == base + 1, "R3 count", 32'(stb_cnt - base), 1);
    chk(last_blk == 1'b0, "R11 reset unlocked", 32'(last_blk), 0);

    load_prot(PMASK);
    // Vector table: R1 R3 R4 R5 R10
    for (int i = 0; i < 7; i++) begin
      base = stb_cnt;
      wr_cycle(VECS[i][28:8], VECS[i][7:0], 4);
      chk(stb_cnt == base + 1, "R3 one strobe", 32'(stb_cnt - base), 1);
      chk(last_addr == VECS[i][28:8], "R1 addr", 32'(last_addr), 32'(VECS[i][28:8]));
      chk(last_data == VECS[i][7:0], "R5 data", 32'(last_data), 32'(VECS[i][7:0]));
      chk(last_blk == lock_of(PMASK, VECS[i][28:8]), "R10 group lock",
          32'(last_blk), 32'(lock_of(PMASK, VECS[i][28:8])));
    end

    // R2: one-sample glitch rejected, exact minimum accepted
    base = stb_cnt;
    wr_cycle(21'h000200, 8'h22, 1);
    chk(stb_cnt == base, "R2 glitch", 32'(stb_cnt - base), 0);
    wr_cycle(21'h000300, 8'h33, 2);
    chk(stb_cnt == base + 1, "R2 min width", 32'(stb_cnt - base), 1);

    // R1: OE low inhibits the start
    base = stb_cnt;
    oe_n = 1'b0;
    wr_cycle(21'h000400, 8'h44, 4);
    oe_n = 1'b1; step(2);
    chk(stb_cnt == base, "R1 oe inhibit", 32'(stb_cnt - base), 0);

    // R4 and R5: mid-cycle changes
    base = stb_cnt;
    addr = 21'h050505; din = 8'hA1; ce_n = 1'b0; we_n = 1'b0;
    step(3);
    addr = 21'h0F0F0F; din = 8'hB2;
    step(2);
    ce_n = 1'b1; we_n = 1'b1; din = 8'hC3;
    step(8);
    chk(stb_cnt == base + 1, "R3 mid count", 32'(stb_cnt - base), 1);
    chk(last_addr == 21'h050505, "R4 first addr", 32'(last_addr), 32'h050505);
    chk(last_data == 8'hB2, "R5 last data", 32'(last_data), 32'hB2);

    // R6: OE falls mid-cycle
    base = stb_cnt;
    ce_n = 1'b0; we_n = 1'b0; step(4);
    oe_n = 1'b0; step(3);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; step(8);
    chk(stb_cnt == base, "R6 oe cancel", 32'(stb_cnt - base), 0);

    // R7: in-progress cycle discarded under low supply
    base = stb_cnt;
    ce_n = 1'b0; we_n = 1'b0; step(4);
    supply_low = 1'b1; step(4);
    chk(cmd_reset == 1'b1, "R7 cmd_reset", 32'(cmd_reset), 1);
    ce_n = 1'b1; we_n = 1'b1; step(4);
    supply_low = 1'b0; step(10);
    chk(stb_cnt == base, "R7 discarded", 32'(stb_cnt - base), 0);
    chk(cmd_reset == 1'b0, "R7 recovered", 32'(cmd_reset), 0);

    // R8: level held across lockout gives no strobe
    base = stb_cnt;
    ce_n = 1'b0; we_n = 1'b0; supply_low = 1'b1; step(6);
    supply_low = 1'b0; step(12);
    ce_n = 1'b1; we_n = 1'b1; step(8);
    chk(stb_cnt == base, "R8 unarmed", 32'(stb_cnt - base), 0);
    wr_cycle(21'h060000, 8'h66, 4);
    chk(stb_cnt == base + 1, "R8 rearmed", 32'(stb_cnt - base), 1);

    // R9: reset pin low
    base = stb_cnt;
    rp_low = 1'b1; step(4);
    chk(cmd_reset == 1'b1, "R9 pin low", 32'(cmd_reset), 1);
    wr_cycle(21'h070000, 8'h77, 4);
    chk(stb_cnt == base, "R9 pin low no write", 32'(stb_cnt - base), 0);
    rp_low = 1'b0; step(10);
    chk(cmd_reset == 1'b0, "R9 pin release", 32'(cmd_reset), 0);

    // R12: temporary unprotect, then restore
    load_prot(8'hFF);
    rp_hv = 1'b1; step(4);
    wr_cycle(21'h150000, 8'h88, 4);
    chk(last_blk == 1'b0, "R12 hv unlocks", 32'(last_blk), 0);
    rp_hv = 1'b0; step(4);
    wr_cycle(21'h150000, 8'h99, 4);
    chk(last_blk == 1'b1, "R12 restored", 32'(last_blk), 1);

    // R11: reload clears
    load_prot(8'h00);
    wr_cycle(21'h150000, 8'hAA, 4);
    chk(last_blk == 1'b0, "R11 reload", 32'(last_blk), 0);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
    end
  end
endmodule